// File: doc/BRIEF.md
# Subword-Addressable Register File

This block is a bank of eight 32-bit general registers with two read ports and one write port. Any register can act as a source or a destination. Each register index comes with a two-bit part selector, so one physical register can be used as a 32-bit word, as a 16-bit half word, or as an 8-bit byte. The same storage backs every width.

Narrow writes merge into the addressed register. Every bit outside the selected field keeps its old value. Narrow reads return the selected field shifted down to bit 0, with zeros above it. The byte at bits 15:8 can be selected on its own only for registers 0 to 3. Selecting that byte on any higher register is rejected: the error output rises, a write is dropped and a read returns zero.

Reads are combinational from the stored state, so a read of the register being written in the same cycle returns the old contents. The file is meant to sit between an instruction decoder and an ALU. Neither of those is part of this block.

Top module: `subword_regfile`

## Requirements
- R1: A synchronous active-low reset sets all eight registers to zero at the clock edge where reset is sampled low, whatever the write inputs are.
- R2: Part selector encoding. 0 selects bits 31:0, 1 selects bits 15:0, 2 selects bits 7:0 and 3 selects bits 15:8. Write data is always taken from the low bits of the write data input: bits 31:0, 15:0 or 7:0, with 7:0 also used for the bits 15:8 byte.
- R3: A legal write of 8 or 16 bits changes only the bits of the selected field. All other bits of that register keep their previous value.
- R4: Read data for a 16-bit or 8-bit selection holds the field in its low bits, with every higher bit zero.
- R5: Selector 3 is legal only for register indices 0 to 3. When write enable is high with selector 3 on index 4 to 7, the error output is high in that cycle and no register changes.
- R6: A read port with selector 3 on index 4 to 7 drives zero on its data output and raises the error output in that cycle.
- R7: A read of a register that is being written in the same cycle returns the value held before the write. The new value is visible on the read port after the next rising clock edge.
- R8: The two read ports are independent, and a write modifies only the register whose index it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_sel | input | 2 | Write part selector |
| wr_data | input | 32 | Write data, right-aligned |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_sel | input | 2 | Read port 0 part selector |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_sel | input | 2 | Read port 1 part selector |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| sel_err | output | 1 | High when any port uses an illegal high-byte selection |

## Verification
A single register is built up by a word write and then overwritten by a low-byte, a high-byte and a half-word write, each with junk in the unused upper data bits. After every step the register is read back as a full word and as the just-written field. This separates a correct merge from one that clobbers neighbouring bits or takes data from the wrong lane. The same read patterns are applied in the cycle of each write, which separates read-before-write from write-through forwarding. High-byte selections on registers 4 to 7, on both the write port and a read port, are applied next to legal accesses to the same register. These show whether an illegal write is really dropped, whether a rejected read returns zero, and whether the error output stays low for legal traffic.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the subword register file.
// Assumes a two-bit part selector on every register port.
package rf_pkg;
    typedef enum logic [1:0] {
        PART_WORD = 2'd0,   // bits 31:0
        PART_HALF = 2'd1,   // bits 15:0
        PART_BLO  = 2'd2,   // bits 7:0
        PART_BHI  = 2'd3    // bits 15:8
    } part_e;
endpackage

// File: rtl/rf_part_decode.sv
`timescale 1ns/1ps
// Module: rf_part_decode
// Turns a register index and a part selector into a field mask, a lane
// shift and a legality flag. Assumes DW >= 2*BW. The high byte is legal
// only below index HB_REGS.
module rf_part_decode #(
    parameter int DW      = 32,
    parameter int BW      = 8,
    parameter int NREGS   = 8,
    parameter int HB_REGS = 4,
    localparam int IW     = $clog2(NREGS),
    localparam int SW     = $clog2(DW)
) (
    input  logic [IW-1:0] idx,
    input  logic [1:0]    sel,
    output logic [DW-1:0] mask,
    output logic [SW-1:0] shift,
    output logic          legal
);
    import rf_pkg::*;

    localparam logic [DW-1:0] M_BYTE = {{(DW-BW){1'b0}}, {BW{1'b1}}};
    localparam logic [DW-1:0] M_HALF = {{(DW-2*BW){1'b0}}, {(2*BW){1'b1}}};

    // Selects the field mask, the shift and legality for the part.
    always_comb begin
        mask  = '1;
        shift = '0;
        legal = 1'b1;
        case (part_e'(sel))
            PART_WORD: mask = '1;
            PART_HALF: mask = M_HALF;
            PART_BLO:  mask = M_BYTE;
            PART_BHI: begin
                mask  = M_BYTE << BW;
                shift = SW'(BW);
                legal = (32'(idx) < HB_REGS);
            end
            default: mask = '1;
        endcase
    end
endmodule

// File: rtl/rf_write_merge.sv
`timescale 1ns/1ps
// Module: rf_write_merge
// Places right-aligned write data into its lane and merges it with the
// old register value under the field mask. Purely combinational.
module rf_write_merge #(
    parameter int DW = 32,
    localparam int SW = $clog2(DW)
) (
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mask,
    input  logic [SW-1:0] shift,
    output logic [DW-1:0] new_val
);
    // Keeps bits outside the mask and inserts the shifted data inside it.
    always_comb begin
        new_val = (old_val & ~mask) | ((wdata << shift) & mask);
    end
endmodule

// File: rtl/rf_read_extract.sv
`timescale 1ns/1ps
// Module: rf_read_extract
// Pulls the selected field out of a register and right-aligns it with
// zero fill. A rejected selection gives zero. Purely combinational.
module rf_read_extract #(
    parameter int DW = 32,
    localparam int SW = $clog2(DW)
) (
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] mask,
    input  logic [SW-1:0] shift,
    input  logic          legal,
    output logic [DW-1:0] rdata
);
    // Masks, shifts down and zeroes a rejected selection.
    always_comb begin
        rdata = legal ? ((reg_val & mask) >> shift) : '0;
    end
endmodule

// File: rtl/subword_regfile.sv
`timescale 1ns/1ps
// Module: subword_regfile
// Eight-entry register file with two combinational read ports and one
// write port. Each port addresses the word, the low half, the low byte,
// or (for indices below HB_REGS) the second byte. Reads see the state
// before the current cycle's write. Reset is synchronous, active low.
module subword_regfile #(
    parameter int DW      = 32,
    parameter int BW      = 8,
    parameter int NREGS   = 8,
    parameter int HB_REGS = 4,
    localparam int IW     = $clog2(NREGS),
    localparam int SW     = $clog2(DW),
    localparam int NRD    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd0_idx,
    input  logic [1:0]    rd0_sel,
    output logic [DW-1:0] rd0_data,
    input  logic [IW-1:0] rd1_idx,
    input  logic [1:0]    rd1_sel,
    output logic [DW-1:0] rd1_data,
    output logic          sel_err
);
    logic [DW-1:0] regs [NREGS];

    // Write path decode and merge.
    logic [DW-1:0] w_mask;
    logic [SW-1:0] w_shift;
    logic          w_legal;
    logic [DW-1:0] w_merged;

    rf_part_decode #(.DW(DW), .BW(BW), .NREGS(NREGS), .HB_REGS(HB_REGS)) u_wdec (
        .idx(wr_idx), .sel(wr_sel), .mask(w_mask), .shift(w_shift), .legal(w_legal)
    );

    rf_write_merge #(.DW(DW)) u_wmerge (
        .old_val(regs[wr_idx]), .wdata(wr_data), .mask(w_mask),
        .shift(w_shift), .new_val(w_merged)
    );

    // Read ports gathered into arrays so one generate loop serves both.
    logic [IW-1:0] r_idx   [NRD];
    logic [1:0]    r_sel   [NRD];
    logic [DW-1:0] r_data  [NRD];
    logic          r_legal [NRD];

    // Maps the port pins onto the read-port arrays.
    always_comb begin
        r_idx[0] = rd0_idx;
        r_sel[0] = rd0_sel;
        r_idx[1] = rd1_idx;
        r_sel[1] = rd1_sel;
        rd0_data = r_data[0];
        rd1_data = r_data[1];
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [DW-1:0] r_mask;
        logic [SW-1:0] r_shift;

        rf_part_decode #(.DW(DW), .BW(BW), .NREGS(NREGS), .HB_REGS(HB_REGS)) u_rdec (
            .idx(r_idx[p]), .sel(r_sel[p]), .mask(r_mask), .shift(r_shift),
            .legal(r_legal[p])
        );

        rf_read_extract #(.DW(DW)) u_rext (
            .reg_val(regs[r_idx[p]]), .mask(r_mask), .shift(r_shift),
            .legal(r_legal[p]), .rdata(r_data[p])
        );
    end

    // Flags any illegal high-byte selection on an active port.
    always_comb begin
        sel_err = (wr_en && !w_legal) || !r_legal[0] || !r_legal[1];
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        // Clears on reset, else loads the merged value when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && w_legal && (32'(wr_idx) == i))
                regs[i] <= w_merged;
        end

        // R3
        keep_unaddressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && w_legal && (32'(wr_idx) == i)) |=>
            ((regs[i] & ~$past(w_mask)) == ($past(regs[i]) & ~$past(w_mask))));

        // R5
        illegal_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_sel == 2'd3) && (32'(wr_idx) >= HB_REGS)) |=> $stable(regs[i]));

        // R8
        other_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (32'(wr_idx) == i)) |=> $stable(regs[i]));
    end

    // R5
    illegal_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd3) && (32'(wr_idx) >= HB_REGS)) |-> sel_err);

    // R4
    rd0_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_sel != 2'd0) |-> (rd0_data[DW-1:2*BW] == '0));

    // R4
    rd1_byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_sel[1]) |-> (rd1_data[DW-1:BW] == '0));

    // R6
    illegal_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd0_sel == 2'd3) && (32'(rd0_idx) >= HB_REGS)) |-> ((rd0_data == '0) && sel_err));
endmodule

// File: tb/sim_subword_regfile.sv
`timescale 1ns/1ps
// Bench for subword_regfile: a vector table walked in one loop, then
// directed reset and corner-case checks.
module sim_subword_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd0_idx = '0;
    logic [1:0]  rd0_sel = '0;
    logic [31:0] rd0_data;
    logic [2:0]  rd1_idx = '0;
    logic [1:0]  rd1_sel = '0;
    logic [31:0] rd1_data;
    logic        sel_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    subword_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_sel(rd0_sel), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_sel(rd1_sel), .rd1_data(rd1_data),
        .sel_err(sel_err)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  widx;
        logic [1:0]  wsel;
        logic [31:0] wdat;
        logic [2:0]  a_idx;
        logic [1:0]  a_sel;
        logic [31:0] a_exp;
        logic [2:0]  b_idx;
        logic [1:0]  b_sel;
        logic [31:0] b_exp;
        logic        e_exp;
    } vec_t;

    // Selector: 0 word, 1 half, 2 low byte, 3 high byte (R2).
    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'd0, 2'd0, 32'h11223344, 3'd0, 2'd0, 32'h00000000, 3'd1, 2'd0, 32'h00000000, 1'b0},
        '{1'b1, 3'd0, 2'd2, 32'hAAAAAA55, 3'd0, 2'd0, 32'h11223344, 3'd0, 2'd3, 32'h00000033, 1'b0},
        '{1'b1, 3'd0, 2'd3, 32'hFFFFFF66, 3'd0, 2'd0, 32'h11223355, 3'd0, 2'd2, 32'h00000055, 1'b0},
        '{1'b1, 3'd0, 2'd1, 32'hDEADBEEF, 3'd0, 2'd0, 32'h11226655, 3'd0, 2'd1, 32'h00006655, 1'b0},
        '{1'b1, 3'd5, 2'd0, 32'hCAFEF00D, 3'd0, 2'd0, 32'h1122BEEF, 3'd0, 2'd3, 32'h000000BE, 1'b0},
        '{1'b1, 3'd5, 2'd3, 32'h000000AB, 3'd5, 2'd0, 32'hCAFEF00D, 3'd5, 2'd2, 32'h0000000D, 1'b1},
        '{1'b1, 3'd5, 2'd2, 32'h00000012, 3'd5, 2'd0, 32'hCAFEF00D, 3'd5, 2'd1, 32'h0000F00D, 1'b0},
        '{1'b1, 3'd3, 2'd3, 32'h00000077, 3'd5, 2'd0, 32'hCAFEF012, 3'd3, 2'd0, 32'h00000000, 1'b0},
        '{1'b1, 3'd7, 2'd1, 32'h12345678, 3'd3, 2'd0, 32'h00007700, 3'd3, 2'd3, 32'h00000077, 1'b0},
        '{1'b0, 3'd6, 2'd3, 32'h0000FFFF, 3'd7, 2'd0, 32'h00005678, 3'd5, 2'd3, 32'h00000000, 1'b1},
        '{1'b0, 3'd0, 2'd0, 32'h00000000, 3'd0, 2'd2, 32'h000000EF, 3'd3, 2'd2, 32'h00000000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: registers read zero after reset
        @(negedge clk);
        rd0_idx = 3'd0; rd0_sel = 2'd0; rd1_idx = 3'd7; rd1_sel = 2'd0;
        #2;
        check("R1 reset r0", rd0_data, 32'h0);
        check("R1 reset r7", rd1_data, 32'h0);

        // Table: reads sampled before the edge that commits the write (R7).
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            wr_en = TBL[k].we; wr_idx = TBL[k].widx; wr_sel = TBL[k].wsel;
            wr_data = TBL[k].wdat;
            rd0_idx = TBL[k].a_idx; rd0_sel = TBL[k].a_sel;
            rd1_idx = TBL[k].b_idx; rd1_sel = TBL[k].b_sel;
            #2;
            check($sformatf("R2/R3/R4/R7 vec%0d port0", k), rd0_data, TBL[k].a_exp);
            check($sformatf("R4/R6/R8 vec%0d port1", k), rd1_data, TBL[k].b_exp);
            check($sformatf("R5/R6 vec%0d err", k), {31'b0, sel_err}, {31'b0, TBL[k].e_exp});
        end

        // R7: written value visible after the edge.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_sel = 2'd0; wr_data = 32'h0BADF00D;
        rd0_idx = 3'd2; rd0_sel = 2'd0; rd1_idx = 3'd2; rd1_sel = 2'd0;
        #2;
        check("R7 same-cycle old value", rd0_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check("R7 new value after edge", rd1_data, 32'h0BADF00D);

        // R5: illegal high-byte write on index 4 leaves it zero.
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_sel = 2'd3; wr_data = 32'hFFFFFFFF;
        rd0_idx = 3'd4; rd0_sel = 2'd0;
        #2;
        check("R5 err on illegal write", {31'b0, sel_err}, 32'h1);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd0;
        #2;
        check("R5 r4 unchanged", rd0_data, 32'h0);
        check("R5 err low after", {31'b0, sel_err}, 32'h0);

        // R1: synchronous reset with a write pending clears everything.
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_idx = 3'd1; wr_sel = 2'd0; wr_data = 32'h55555555;
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
        rd0_idx = 3'd0; rd0_sel = 2'd0; rd1_idx = 3'd1; rd1_sel = 2'd0;
        #2;
        check("R1 r0 cleared", rd0_data, 32'h0);
        check("R1 r1 write blocked by reset", rd1_data, 32'h0);
        rd0_idx = 3'd5; rd1_idx = 3'd2;
        #1;
        check("R1 r5 cleared", rd0_data, 32'h0);
        check("R1 r2 cleared", rd1_data, 32'h0);

        finish_run();
    end
endmodule